// File: doc/BRIEF.md
# Dual-Clock Nine-Bit FIFO with Programmable Level Thresholds

This block is a first-in first-out buffer for 9-bit words. A producer writes on its own clock and a consumer reads on another. The two clocks may run at any ratio, or they may be tied to one source. Each side is qualified by two enables. Four status outputs, all active low, report the buffer's state: empty, full, almost-empty and almost-full. The two "almost" thresholds are held in internal registers with single-word resolution. After reset, each threshold is 7.

The thresholds are programmed through the data input. While the mode input `wr_sel` is low, each write-side strobe stores `din` into the next of four threshold slots instead of into the buffer. While `wr_sel` is low, read-side strobes place the same slots, in the same order, on the output register, so software can read them back. Data crosses between the clock domains as Gray-coded pointers through two-flop synchronizers. Each domain computes its own flags from its local pointer and the synchronized remote pointer. The output stage is a register. An output-enable input either presents that register or models a released bus: the data is forced to zero and the `dout_on` indicator is low. Depth is a power-of-two parameter.

Top module: `fifo9_dc`

## Requirements
- R1: Words accepted on the write side leave `dout` in acceptance order. A read takes place on a `rd_clk` rising edge when `rd_en_n` and `rd_en2_n` are both low, `wr_sel` is high and the buffer is not empty, and `dout` shows the word from that edge onward. A write takes place on a `wr_clk` rising edge when `wr_en_n` is low, `wr_sel` is high and the buffer is not full. This holds whatever the clock ratio.
- R2: While and after the asynchronous reset `arst_n` is low, `empty_n` and `almost_empty_n` are 0, `full_n` and `almost_full_n` are 1, the output register is 0, and both thresholds are 7.
- R3: `empty_n` rises within three `rd_clk` rising edges after the write edge that fills an empty buffer. It falls right after the read edge that removes the last stored word.
- R4: `full_n` is 0 whenever DEPTH words are held, counted from the write side. A write attempted while `full_n` is 0 stores nothing.
- R5: A read attempted while `empty_n` is 0 leaves the output register unchanged.
- R6: `almost_empty_n` is 0 while the stored count, counted from the read side, is less than or equal to the almost-empty threshold, and 1 when the count is above it.
- R7: `almost_full_n` is 0 while the free count, counted from the write side, is less than or equal to the almost-full threshold, and 1 when the free count is above it.
- R8: With `wr_sel` low, each `wr_clk` edge with `wr_en_n` low stores `din` into the next threshold slot and stores no data word. The slots are taken in this order: 0 = almost-empty bits 8:0, 1 = almost-empty bits 17:9, 2 = almost-full bits 8:0, 3 = almost-full bits 17:9. After slot 3 the order wraps to slot 0.
- R9: With `wr_sel` low, each `rd_clk` edge with both read enables low loads the next threshold slot, in the R8 order with wrap, into the output register. It removes no data word.
- R10: With `out_en_n` high, `dout` is 0 and `dout_on` is 0. With `out_en_n` low, `dout_on` is 1 and `dout` equals the output register, which keeps its value across the released interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| arst_n | input | 1 | Asynchronous reset, active low, both domains |
| din | input | 9 | Data word or threshold slot value |
| wr_en_n | input | 1 | Write strobe, active low |
| wr_sel | input | 1 | 1 = data transfers, 0 = threshold program/readback |
| rd_en_n | input | 1 | First read strobe, active low |
| rd_en2_n | input | 1 | Second read strobe, active low |
| out_en_n | input | 1 | Output enable, active low |
| dout | output | 9 | Output register, or 0 when released |
| dout_on | output | 1 | High when the output is driven |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| almost_empty_n | output | 1 | Almost-empty flag, active low |
| almost_full_n | output | 1 | Almost-full flag, active low |

## Verification
Flags computed against a local pointer move right after the edge that advances that pointer. A write updates `full_n` and `almost_full_n` at the write edge itself, and a read updates `empty_n` and `almost_empty_n` at the read edge itself. A flag that depends on the far pointer changes only after that pointer's Gray copy has passed two flops in the observing domain, about three observing-clock edges. So the checks on those flags wait a fixed settle window of four edges on each clock before they sample. Read data and readback slot values appear in the output register at the read edge that consumes them. A monitor compares them at the following falling read-clock edge against a queue filled by the write driver, and the driver queues only words offered while `full_n` was high.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;
  localparam int WORD_W    = 9;
  localparam int OFS_PARTS = 4;
  localparam int OFS_W     = 2 * WORD_W;
  localparam logic [WORD_W-1:0] OFS_RESET_LO = 9'd7;

  // Threshold slot order; programming and readback both walk it.
  typedef enum logic [1:0] {
    SLOT_AE_LO = 2'd0,
    SLOT_AE_HI = 2'd1,
    SLOT_AF_LO = 2'd2,
    SLOT_AF_HI = 2'd3
  } ofs_slot_e;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Distance from lag to lead for pointers that wrap at 2**span_log2.
  function automatic logic [31:0] ptr_gap(input logic [31:0] lead,
                                          input logic [31:0] lag,
                                          input int unsigned span_log2);
    logic [31:0] mask;
    mask = (32'd1 << span_log2) - 32'd1;
    return (lead - lag) & mask;
  endfunction
endpackage

// File: rtl/fifo9_ptr_sync.sv
module fifo9_ptr_sync
  import fifo9_pkg::*;
#(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= gray_in;
      stab_q <= meta_q;
    end
  end

  assign bin_out = PW'(from_gray(32'(stab_q)));
endmodule

// File: rtl/fifo9_store.sv
module fifo9_store
  import fifo9_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic              wr_clk,
  input  logic              wr_do,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] cell_q [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_do) cell_q[wr_addr] <= wr_word;
  end

  assign rd_word = cell_q[rd_addr];
endmodule

// File: rtl/fifo9_wside.sv
module fifo9_wside
  import fifo9_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int PW    = AW + 1
) (
  input  logic                        wr_clk,
  input  logic                        arst_n,
  input  logic [WORD_W-1:0]           din,
  input  logic                        wr_en_n,
  input  logic                        wr_sel,
  input  logic [PW-1:0]               rd_gray,
  output logic                        wr_do,
  output logic [AW-1:0]               wr_addr,
  output logic [PW-1:0]               wr_gray,
  output logic [OFS_PARTS*WORD_W-1:0] ofs_flat,
  output logic                        full_n,
  output logic                        almost_full_n
);
  logic [PW-1:0]     wptr_q, wptr_nx, wgray_q, rbin_s;
  logic [WORD_W-1:0] ofs_q [OFS_PARTS];
  ofs_slot_e         ld_idx_q;
  logic [31:0]       used_w, free_w;
  logic [OFS_W-1:0]  af_off;

  // Named events for the assertions.
  logic wr_req, prog_req;
  assign wr_req   = !wr_en_n && wr_sel;
  assign prog_req = !wr_en_n && !wr_sel;

  fifo9_ptr_sync #(.PW(PW)) u_rsync (
    .clk(wr_clk), .arst_n(arst_n), .gray_in(rd_gray), .bin_out(rbin_s)
  );

  assign used_w        = ptr_gap(32'(wptr_q), 32'(rbin_s), PW);
  assign free_w        = 32'(DEPTH) - used_w;
  assign af_off        = {ofs_q[SLOT_AF_HI], ofs_q[SLOT_AF_LO]};
  assign full_n        = (used_w != 32'(DEPTH));
  assign almost_full_n = (free_w > 32'(af_off));
  assign wr_do         = wr_req && full_n;
  assign wptr_nx       = wptr_q + 1'b1;
  assign wr_addr       = wptr_q[AW-1:0];
  assign wr_gray       = wgray_q;

  always_ff @(posedge wr_clk or negedge arst_n) begin
    if (!arst_n) begin
      wptr_q  <= '0;
      wgray_q <= '0;
    end else if (wr_do) begin
      wptr_q  <= wptr_nx;
      wgray_q <= PW'(to_gray(32'(wptr_nx)));
    end
  end

  always_ff @(posedge wr_clk or negedge arst_n) begin
    if (!arst_n) begin
      ld_idx_q <= SLOT_AE_LO;
      for (int i = 0; i < OFS_PARTS; i++)
        ofs_q[i] <= (i == int'(SLOT_AE_LO) || i == int'(SLOT_AF_LO)) ? OFS_RESET_LO : '0;
    end else if (prog_req) begin
      ofs_q[ld_idx_q] <= din;
      ld_idx_q        <= ofs_slot_e'(ld_idx_q + 2'd1);
    end
  end

  for (genvar g = 0; g < OFS_PARTS; g++) begin : g_flat
    assign ofs_flat[g*WORD_W +: WORD_W] = ofs_q[g];
  end

  // R4
  level_bound_chk: assert property (@(posedge wr_clk) disable iff (!arst_n)
    used_w <= 32'(DEPTH));
  // R4
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!arst_n)
    (!full_n && wr_req) |=> $stable(wptr_q));
  // R7
  full_implies_af_chk: assert property (@(posedge wr_clk) disable iff (!arst_n)
    !full_n |-> !almost_full_n);
  // R8
  prog_keeps_data_chk: assert property (@(posedge wr_clk) disable iff (!arst_n)
    prog_req |=> $stable(wptr_q));
endmodule

// File: rtl/fifo9_rside.sv
module fifo9_rside
  import fifo9_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int PW    = AW + 1
) (
  input  logic                        rd_clk,
  input  logic                        arst_n,
  input  logic                        rd_en_n,
  input  logic                        rd_en2_n,
  input  logic                        wr_sel,
  input  logic                        out_en_n,
  input  logic [PW-1:0]               wr_gray,
  input  logic [OFS_PARTS*WORD_W-1:0] ofs_flat,
  input  logic [WORD_W-1:0]           rd_word,
  output logic [AW-1:0]               rd_addr,
  output logic [PW-1:0]               rd_gray,
  output logic [WORD_W-1:0]           dout,
  output logic                        dout_on,
  output logic                        empty_n,
  output logic                        almost_empty_n
);
  logic [PW-1:0]     rptr_q, rptr_nx, rgray_q, wbin_s;
  logic [WORD_W-1:0] out_q;
  logic [WORD_W-1:0] ofs_w [OFS_PARTS];
  ofs_slot_e         rb_idx_q;
  logic [31:0]       used_w;
  logic [OFS_W-1:0]  ae_off;

  // Named events for the assertions.
  logic rd_req, rb_req, rd_do;
  assign rd_req = !rd_en_n && !rd_en2_n && wr_sel;
  assign rb_req = !rd_en_n && !rd_en2_n && !wr_sel;

  fifo9_ptr_sync #(.PW(PW)) u_wsync (
    .clk(rd_clk), .arst_n(arst_n), .gray_in(wr_gray), .bin_out(wbin_s)
  );

  for (genvar g = 0; g < OFS_PARTS; g++) begin : g_unflat
    assign ofs_w[g] = ofs_flat[g*WORD_W +: WORD_W];
  end

  assign used_w         = ptr_gap(32'(wbin_s), 32'(rptr_q), PW);
  assign ae_off         = {ofs_w[SLOT_AE_HI], ofs_w[SLOT_AE_LO]};
  assign empty_n        = (used_w != 32'd0);
  assign almost_empty_n = (used_w > 32'(ae_off));
  assign rd_do          = rd_req && empty_n;
  assign rptr_nx        = rptr_q + 1'b1;
  assign rd_addr        = rptr_q[AW-1:0];
  assign rd_gray        = rgray_q;
  assign dout_on        = !out_en_n;
  assign dout           = out_en_n ? '0 : out_q;

  always_ff @(posedge rd_clk or negedge arst_n) begin
    if (!arst_n) begin
      rptr_q  <= '0;
      rgray_q <= '0;
    end else if (rd_do) begin
      rptr_q  <= rptr_nx;
      rgray_q <= PW'(to_gray(32'(rptr_nx)));
    end
  end

  always_ff @(posedge rd_clk or negedge arst_n) begin
    if (!arst_n) begin
      out_q    <= '0;
      rb_idx_q <= SLOT_AE_LO;
    end else if (rd_do) begin
      out_q <= rd_word;
    end else if (rb_req) begin
      out_q    <= ofs_w[rb_idx_q];
      rb_idx_q <= ofs_slot_e'(rb_idx_q + 2'd1);
    end
  end

  // R5
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!arst_n)
    (!empty_n && rd_req) |=> $stable(out_q));
  // R6
  empty_implies_ae_chk: assert property (@(posedge rd_clk) disable iff (!arst_n)
    !empty_n |-> !almost_empty_n);
  // R9
  readback_keeps_data_chk: assert property (@(posedge rd_clk) disable iff (!arst_n)
    rb_req |=> $stable(rptr_q));
  // R3
  last_read_empties_chk: assert property (@(posedge rd_clk) disable iff (!arst_n)
    (rd_do && used_w == 32'd1 && $stable(wbin_s)) |=> !empty_n);
endmodule

// File: rtl/fifo9_dc.sv
module fifo9_dc
  import fifo9_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              arst_n,
  input  logic [WORD_W-1:0] din,
  input  logic              wr_en_n,
  input  logic              wr_sel,
  input  logic              rd_en_n,
  input  logic              rd_en2_n,
  input  logic              out_en_n,
  output logic [WORD_W-1:0] dout,
  output logic              dout_on,
  output logic              empty_n,
  output logic              full_n,
  output logic              almost_empty_n,
  output logic              almost_full_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic                        wr_do;
  logic [AW-1:0]               wr_addr, rd_addr;
  logic [PW-1:0]               wr_gray, rd_gray;
  logic [OFS_PARTS*WORD_W-1:0] ofs_flat;
  logic [WORD_W-1:0]           rd_word;

  fifo9_wside #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wside (
    .wr_clk(wr_clk), .arst_n(arst_n), .din(din), .wr_en_n(wr_en_n),
    .wr_sel(wr_sel), .rd_gray(rd_gray), .wr_do(wr_do), .wr_addr(wr_addr),
    .wr_gray(wr_gray), .ofs_flat(ofs_flat), .full_n(full_n),
    .almost_full_n(almost_full_n)
  );

  fifo9_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .wr_clk(wr_clk), .wr_do(wr_do), .wr_addr(wr_addr), .wr_word(din),
    .rd_addr(rd_addr), .rd_word(rd_word)
  );

  fifo9_rside #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rside (
    .rd_clk(rd_clk), .arst_n(arst_n), .rd_en_n(rd_en_n), .rd_en2_n(rd_en2_n),
    .wr_sel(wr_sel), .out_en_n(out_en_n), .wr_gray(wr_gray),
    .ofs_flat(ofs_flat), .rd_word(rd_word), .rd_addr(rd_addr),
    .rd_gray(rd_gray), .dout(dout), .dout_on(dout_on), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n)
  );

  // R10
  released_bus_chk: assert property (@(posedge rd_clk) disable iff (!arst_n)
    out_en_n |-> (dout == '0 && !dout_on));
endmodule

// File: tb/fifo9_dc_tb.sv
module fifo9_dc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = CLK_PERIOD + (CLK_PERIOD * 2) / 5;
  localparam int DEPTH      = 32;

  logic       wr_clk = 1'b0, rd_clk = 1'b0, arst_n = 1'b0;
  logic [8:0] din = '0;
  logic       wr_en_n = 1'b1, wr_sel = 1'b1;
  logic       rd_en_n = 1'b1, rd_en2_n = 1'b1, out_en_n = 1'b0;
  logic [8:0] dout;
  logic       dout_on, empty_n, full_n, almost_empty_n, almost_full_n;

  int checks = 0, errors = 0;
  logic [8:0] exp_q[$];
  logic       fire = 1'b0;
  logic [8:0] seed = 9'h0A5;
  logic [8:0] held;
  logic       finished = 1'b0;

  fifo9_dc #(.DEPTH(DEPTH)) dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .arst_n(arst_n), .din(din),
    .wr_en_n(wr_en_n), .wr_sel(wr_sel), .rd_en_n(rd_en_n), .rd_en2_n(rd_en2_n),
    .out_en_n(out_en_n), .dout(dout), .dout_on(dout_on), .empty_n(empty_n),
    .full_n(full_n), .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
  );

  always #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
  always #(RD_PERIOD / 2)  rd_clk = ~rd_clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Driver: queue only words offered while the buffer reported room (R4).
  task automatic push_word(input logic [8:0] w);
    @(negedge wr_clk);
    wr_sel = 1'b1; wr_en_n = 1'b0; din = w;
    if (full_n) exp_q.push_back(w);
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      seed = {seed[7:0], seed[8] ^ seed[4]};
      push_word(seed);
    end
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  task automatic pull_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      rd_en_n = 1'b0; rd_en2_n = 1'b0;
    end
    @(negedge rd_clk);
    rd_en_n = 1'b1; rd_en2_n = 1'b1;
  endtask

  task automatic settle();
    repeat (4) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
  endtask

  // Monitor: a data read at a rising edge is due at the next falling edge (R1).
  always @(posedge rd_clk) fire <= arst_n && !rd_en_n && !rd_en2_n && wr_sel && empty_n;

  always @(negedge rd_clk) begin
    if (fire) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected read", 32'(dout), 32'h0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk(dout == e, "R1 data order", 32'(dout), 32'(e));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [8:0] prog_v [4];
    prog_v[0] = 9'd3; prog_v[1] = 9'd0; prog_v[2] = 9'd5; prog_v[3] = 9'd0;

    #(CLK_PERIOD * 3 + 8);
    arst_n = 1'b1;
    settle();
    // R2 reset state
    chk(empty_n == 1'b0, "R2 empty_n", 32'(empty_n), 32'h0);
    chk(almost_empty_n == 1'b0, "R2 almost_empty_n", 32'(almost_empty_n), 32'h0);
    chk(full_n == 1'b1, "R2 full_n", 32'(full_n), 32'h1);
    chk(almost_full_n == 1'b1, "R2 almost_full_n", 32'(almost_full_n), 32'h1);
    chk(dout == 9'h0, "R2 dout", 32'(dout), 32'h0);

    // R3 / R6 with the default threshold of 7 (R2)
    push_n(7);
    settle();
    chk(empty_n == 1'b1, "R3 empty_n after writes", 32'(empty_n), 32'h1);
    chk(almost_empty_n == 1'b0, "R6 seven words at threshold 7", 32'(almost_empty_n), 32'h0);
    push_n(1);
    settle();
    chk(almost_empty_n == 1'b1, "R6 eight words above threshold 7", 32'(almost_empty_n), 32'h1);

    // R1 drain
    pull_n(8);
    settle();
    chk(empty_n == 1'b0, "R3 empty_n after last read", 32'(empty_n), 32'h0);
    chk(exp_q.size() == 0, "R1 all words read", 32'(exp_q.size()), 32'h0);

    // R5 read while empty
    held = dout;
    pull_n(3);
    settle();
    chk(dout == held, "R5 dout held on empty read", 32'(dout), 32'(held));

    // R7 / R4 fill
    push_n(DEPTH - 8);
    settle();
    chk(almost_full_n == 1'b1, "R7 free 8 above threshold 7", 32'(almost_full_n), 32'h1);
    push_n(1);
    settle();
    chk(almost_full_n == 1'b0, "R7 free 7 at threshold 7", 32'(almost_full_n), 32'h0);
    push_n(7);
    settle();
    chk(full_n == 1'b0, "R4 full_n at depth", 32'(full_n), 32'h0);
    push_n(3);
    settle();
    chk(exp_q.size() == DEPTH, "R4 extra writes not queued", 32'(exp_q.size()), 32'(DEPTH));
    pull_n(DEPTH);
    settle();
    chk(empty_n == 1'b0, "R4 nothing stored while full", 32'(empty_n), 32'h0);
    chk(exp_q.size() == 0, "R1 full drain order", 32'(exp_q.size()), 32'h0);

    // R8 program thresholds AE=3, AF=5
    @(negedge wr_clk);
    wr_sel = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge wr_clk);
      wr_en_n = 1'b0; din = prog_v[i];
    end
    @(negedge wr_clk);
    wr_en_n = 1'b1;
    settle();
    chk(empty_n == 1'b0, "R8 programming stores no data", 32'(empty_n), 32'h0);

    // R9 readback of five slots: order then wrap
    @(negedge rd_clk);
    rd_en_n = 1'b0; rd_en2_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge rd_clk);
      if (i == 4) begin rd_en_n = 1'b1; rd_en2_n = 1'b1; end
      chk(dout == prog_v[i % 4], "R9 readback slot", 32'(dout), 32'(prog_v[i % 4]));
    end
    @(negedge wr_clk);
    wr_sel = 1'b1;
    settle();
    chk(empty_n == 1'b0, "R9 readback removes no data", 32'(empty_n), 32'h0);

    // R6 / R7 / R8 with programmed thresholds
    push_n(3);
    settle();
    chk(almost_empty_n == 1'b0, "R8 R6 three words at threshold 3", 32'(almost_empty_n), 32'h0);
    push_n(1);
    settle();
    chk(almost_empty_n == 1'b1, "R8 R6 four words above threshold 3", 32'(almost_empty_n), 32'h1);
    push_n(22);
    settle();
    chk(almost_full_n == 1'b1, "R8 R7 free 6 above threshold 5", 32'(almost_full_n), 32'h1);
    push_n(1);
    settle();
    chk(almost_full_n == 1'b0, "R8 R7 free 5 at threshold 5", 32'(almost_full_n), 32'h0);
    pull_n(27);
    settle();
    chk(exp_q.size() == 0, "R1 drain after programming", 32'(exp_q.size()), 32'h0);

    // R10 output enable
    held = dout;
    @(negedge rd_clk);
    out_en_n = 1'b1;
    @(negedge rd_clk);
    chk(dout == 9'h0, "R10 released dout", 32'(dout), 32'h0);
    chk(dout_on == 1'b0, "R10 released dout_on", 32'(dout_on), 32'h0);
    out_en_n = 1'b0;
    @(negedge rd_clk);
    chk(dout == held, "R10 driven dout kept", 32'(dout), 32'(held));
    chk(dout_on == 1'b1, "R10 driven dout_on", 32'(dout_on), 32'h1);

    // R1 concurrent traffic on both clocks
    fork
      push_n(20);
      pull_n(40);
    join
    pull_n(8);
    settle();
    chk(exp_q.size() == 0, "R1 concurrent stream", 32'(exp_q.size()), 32'h0);
    chk(empty_n == 1'b0, "R3 empty after stream", 32'(empty_n), 32'h0);

    finish_run();
  end
endmodule